// File: doc/BRIEF.md
# Flash Command Interface with Status Register

This block sits between a parallel flash bus and the array control logic. It treats each bus write (address plus 16-bit data word) as part of a one- or two-write command. It steps through setup, busy, suspended and error conditions, and it keeps an 8-bit status word. It also holds one protect bit per erase block. It chooses which source drives the read data: the array, the status word, or an identification space that also carries the protect bit and a fixed configuration word.

Program, erase and blank-check execution is modelled as a down-counter. At the end of the count a single-cycle strobe is sent to an external array stub: a write strobe for program, an erase strobe for erase, and nothing for blank check. Blank check instead samples a blank flag from the stub. One program or erase may be paused and later continued.

The command byte is the low 8 bits of the data word. The block index is the top `BLK_W` bits of the address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status word is 80h and the read source is the array (`rd_src` 0). Every block reads back as protected.
- R2: Writing FFh selects the array as read source (`rd_src` 0). Writing 70h selects the status word (`rd_src` 1, `rd_data` = zero-extended status). Writing 90h selects the identification space (`rd_src` 2), where `rd_addr[1:0]` chooses the word: 0 is the maker code, 1 is the device code, 2 is the protect bit (in bit 0) of the block addressed by `rd_addr`, and 3 is the configuration word.
- R3: Writing 60h and then 01h protects the block named by the second write's address. Writing 60h and then D0h unprotects it. Any other second code sets status bits 5 and 4 together and changes no protect bit.
- R4: Writing 40h or 10h and then a data word starts a program. Status bit 7 reads 0 for exactly `PROG_CYCLES` cycles. Then `arr_we` pulses for one cycle with the data write's address and data.
- R5: Writing 20h and then D0h starts an erase. The bus is busy for `ERASE_CYCLES` cycles. Then `arr_erase` pulses for one cycle with the confirm write's address.
- R6: Writing BCh and then CBh starts a blank check. The bus is busy for `BLANK_CYCLES` cycles and no array strobe is issued. If `arr_blank` is low in the final busy cycle, status bit 5 is set.
- R7: A program or erase aimed at a protected block sets status bit 1. It does not become busy and issues no array strobe.
- R8: After 20h or BCh, any second code other than the matching confirm (D0h or CBh) sets status bits 5 and 4 together. The interface returns to ready without becoming busy.
- R9: If `pp_ok` is low when a program, erase or blank check would start, status bit 3 is set and the operation is dropped. The voltage check is made before the protect check.
- R10: Writing a program, erase or blank-check setup code switches the read source to status. Suspending or resuming does the same.
- R11: While busy, only 70h and B0h take effect. Every other write is ignored, including read-mode, clear and protect codes. A write that arrives in the final busy cycle is dropped.
- R12: B0h during a program or erase clears busy on the next cycle. It sets status bit 2 for a program or bit 6 for an erase, and keeps the remaining count. D0h then resumes, and the operation finishes after exactly the remaining cycles. B0h during a blank check is ignored.
- R13: While an operation is suspended, the read-mode, clear and protect commands work normally. The program, erase and blank-check setup codes are ignored.
- R14: Status bits 5, 4, 3 and 1 stay set until 50h is written outside busy, which clears all four. Status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data; command code in bits 7:0 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data from the selected source |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 identification |
| stat | output | 8 | Status word |
| pp_ok | input | 1 | Programming voltage in range |
| arr_rdata | input | DATA_W | Array data at `rd_addr` from the stub |
| arr_blank | input | 1 | Stub reports the addressed block is blank |
| arr_we | output | 1 | One-cycle program strobe |
| arr_erase | output | 1 | One-cycle erase strobe |
| arr_addr | output | ADDR_W | Address for the array strobe |
| arr_wdata | output | DATA_W | Data for the program strobe |

## Verification
Some properties are checked on every cycle: the suspend flags only appear while the controller reads ready, and the two suspend flags are never set together. Each array strobe lasts one cycle, the two strobes never coincide, and each follows a busy cycle. An error bit only drops right after a clear write.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- the exact busy length before and after a suspend;
- which writes are ignored while busy or suspended;
- the ordering of the voltage and protect checks;
- the identification-space words.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_RD_SIG   = 8'h90;
    localparam logic [7:0] CMD_CLR_SR   = 8'h50;
    localparam logic [7:0] CMD_PROG_A   = 8'h40;
    localparam logic [7:0] CMD_PROG_B   = 8'h10;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_BLANK    = 8'hBC;
    localparam logic [7:0] CMD_BLANK_OK = 8'hCB;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_PROT     = 8'h60;
    localparam logic [7:0] CMD_PROT_ON  = 8'h01;

    typedef enum logic [2:0] {
        PH_IDLE, PH_PROG_SU, PH_ERASE_SU, PH_BLANK_SU, PH_PROT_SU, PH_BUSY
    } phase_e;

    typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_BLANK} op_e;

    typedef enum logic [1:0] {SUS_NONE, SUS_PROG, SUS_ERASE} sus_e;

    typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_SIG} rsrc_e;

endpackage

// File: rtl/fci_timer.sv
module fci_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_one
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_one = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fci_protect.sv
module fci_protect #(
    parameter int BLK_W = 3,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [BLK_W-1:0] sel,
    output logic [NBLK-1:0]  prot
);
    logic [NBLK-1:0] prot_d, prot_q;

    for (genvar i = 0; i < NBLK; i++) begin : g_bit
        always_comb begin
            prot_d[i] = prot_q[i];
            if (sel == BLK_W'(i)) begin
                if (set_en)      prot_d[i] = 1'b1;
                else if (clr_en) prot_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= '1;
        else        prot_q <= prot_d;
    end

    assign prot = prot_q;
endmodule

// File: rtl/fci_rdmux.sv
module fci_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          BLK_W    = 3,
    parameter logic [15:0] MFR_CODE = 16'h00A5,
    parameter logic [15:0] DEV_CODE = 16'h5A3C,
    parameter logic [15:0] CFG_WORD = 16'hBE4F,
    localparam int         NBLK     = 1 << BLK_W
) (
    input  rsrc_e              src,
    input  logic [1:0]         offs,
    input  logic [BLK_W-1:0]   blk,
    input  logic [7:0]         stat,
    input  logic [NBLK-1:0]    prot,
    input  logic [DATA_W-1:0]  arr_rdata,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] sig_word;

    always_comb begin
        case (offs)
            2'd0:    sig_word = DATA_W'(MFR_CODE);
            2'd1:    sig_word = DATA_W'(DEV_CODE);
            2'd2:    sig_word = DATA_W'(prot[blk]);
            default: sig_word = DATA_W'(CFG_WORD);
        endcase
    end

    always_comb begin
        case (src)
            SRC_STATUS: rd_data = DATA_W'(stat);
            SRC_SIG:    rd_data = sig_word;
            default:    rd_data = arr_rdata;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int          DATA_W       = 16,
    parameter int          BLK_W        = 3,
    parameter int          PROG_CYCLES  = 12,
    parameter int          ERASE_CYCLES = 40,
    parameter int          BLANK_CYCLES = 8,
    parameter logic [15:0] MFR_CODE     = 16'h00A5,
    parameter logic [15:0] DEV_CODE     = 16'h5A3C,
    parameter logic [15:0] CFG_WORD     = 16'hBE4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_src,
    output logic [7:0]        stat,
    input  logic              pp_ok,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              arr_blank,
    output logic              arr_we,
    output logic              arr_erase,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int NBLK    = 1 << BLK_W;
    localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAX_CYC = (MAX_A > BLANK_CYCLES) ? MAX_A : BLANK_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        sus_e              sus;
        rsrc_e             mode;
        logic              e_ers;
        logic              e_prg;
        logic              e_vpp;
        logic              e_prt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we;
        logic              er;
    } st_t;

    localparam st_t RESET_ST = '{
        phase: PH_IDLE, op: OP_PROG, sus: SUS_NONE, mode: SRC_ARRAY,
        e_ers: 1'b0, e_prg: 1'b0, e_vpp: 1'b0, e_prt: 1'b0,
        addr: '0, data: '0, we: 1'b0, er: 1'b0
    };

    st_t st_d, st_q;

    logic [7:0]       code;
    logic [BLK_W-1:0] wr_blk;
    logic [NBLK-1:0]  prot;
    logic             tgt_prot;
    logic             tmr_load, tmr_run, tmr_one, done;
    logic [CNT_W-1:0] tmr_val;
    logic             prot_set, prot_clr;

    assign code     = wr_data[7:0];
    assign wr_blk   = wr_addr[ADDR_W-1 -: BLK_W];
    assign tgt_prot = prot[wr_blk];
    assign done     = (st_q.phase == PH_BUSY) && tmr_one;

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.er  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        prot_set = 1'b0;
        prot_clr = 1'b0;

        case (st_q.phase)
            PH_IDLE: if (wr_en) begin
                case (code)
                    CMD_RD_ARRAY: st_d.mode = SRC_ARRAY;
                    CMD_RD_STAT:  st_d.mode = SRC_STATUS;
                    CMD_RD_SIG:   st_d.mode = SRC_SIG;
                    CMD_CLR_SR: begin
                        st_d.e_ers = 1'b0;
                        st_d.e_prg = 1'b0;
                        st_d.e_vpp = 1'b0;
                        st_d.e_prt = 1'b0;
                    end
                    CMD_PROT: st_d.phase = PH_PROT_SU;
                    CMD_PROG_A, CMD_PROG_B: if (st_q.sus == SUS_NONE) begin
                        st_d.phase = PH_PROG_SU;
                        st_d.mode  = SRC_STATUS;
                    end
                    CMD_ERASE: if (st_q.sus == SUS_NONE) begin
                        st_d.phase = PH_ERASE_SU;
                        st_d.mode  = SRC_STATUS;
                    end
                    CMD_BLANK: if (st_q.sus == SUS_NONE) begin
                        st_d.phase = PH_BLANK_SU;
                        st_d.mode  = SRC_STATUS;
                    end
                    CMD_CONFIRM: if (st_q.sus != SUS_NONE) begin
                        st_d.phase = PH_BUSY;
                        st_d.sus   = SUS_NONE;
                        st_d.mode  = SRC_STATUS;
                    end
                    default: ;
                endcase
            end

            PH_PROG_SU: if (wr_en) begin
                st_d.phase = PH_IDLE;
                if (!pp_ok)
                    st_d.e_vpp = 1'b1;
                else if (tgt_prot)
                    st_d.e_prt = 1'b1;
                else begin
                    st_d.phase = PH_BUSY;
                    st_d.op    = OP_PROG;
                    st_d.addr  = wr_addr;
                    st_d.data  = wr_data;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(PROG_CYCLES);
                end
            end

            PH_ERASE_SU: if (wr_en) begin
                st_d.phase = PH_IDLE;
                if (code != CMD_CONFIRM) begin
                    st_d.e_ers = 1'b1;
                    st_d.e_prg = 1'b1;
                end else if (!pp_ok)
                    st_d.e_vpp = 1'b1;
                else if (tgt_prot)
                    st_d.e_prt = 1'b1;
                else begin
                    st_d.phase = PH_BUSY;
                    st_d.op    = OP_ERASE;
                    st_d.addr  = wr_addr;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(ERASE_CYCLES);
                end
            end

            PH_BLANK_SU: if (wr_en) begin
                st_d.phase = PH_IDLE;
                if (code != CMD_BLANK_OK) begin
                    st_d.e_ers = 1'b1;
                    st_d.e_prg = 1'b1;
                end else if (!pp_ok)
                    st_d.e_vpp = 1'b1;
                else begin
                    st_d.phase = PH_BUSY;
                    st_d.op    = OP_BLANK;
                    st_d.addr  = wr_addr;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(BLANK_CYCLES);
                end
            end

            PH_PROT_SU: if (wr_en) begin
                st_d.phase = PH_IDLE;
                if (code == CMD_PROT_ON)
                    prot_set = 1'b1;
                else if (code == CMD_CONFIRM)
                    prot_clr = 1'b1;
                else begin
                    st_d.e_ers = 1'b1;
                    st_d.e_prg = 1'b1;
                end
            end

            PH_BUSY: begin
                if (done) begin
                    st_d.phase = PH_IDLE;
                    case (st_q.op)
                        OP_PROG:  st_d.we = 1'b1;
                        OP_ERASE: st_d.er = 1'b1;
                        default:  if (!arr_blank) st_d.e_ers = 1'b1;
                    endcase
                end else if (wr_en) begin
                    if (code == CMD_RD_STAT)
                        st_d.mode = SRC_STATUS;
                    else if (code == CMD_SUSPEND && st_q.op != OP_BLANK) begin
                        st_d.phase = PH_IDLE;
                        st_d.sus   = (st_q.op == OP_PROG) ? SUS_PROG : SUS_ERASE;
                        st_d.mode  = SRC_STATUS;
                    end
                end
            end

            default: st_d.phase = PH_IDLE;
        endcase

        tmr_run = (st_q.phase == PH_BUSY) && (st_d.phase == PH_BUSY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    fci_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .at_one   (tmr_one)
    );

    fci_protect #(.BLK_W(BLK_W)) u_protect (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (prot_set),
        .clr_en (prot_clr),
        .sel    (wr_blk),
        .prot   (prot)
    );

    assign stat = {st_q.phase != PH_BUSY, st_q.sus == SUS_ERASE, st_q.e_ers, st_q.e_prg,
                   st_q.e_vpp, st_q.sus == SUS_PROG, st_q.e_prt, 1'b0};

    fci_rdmux #(
        .DATA_W   (DATA_W),
        .BLK_W    (BLK_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE),
        .CFG_WORD (CFG_WORD)
    ) u_rdmux (
        .src       (st_q.mode),
        .offs      (rd_addr[1:0]),
        .blk       (rd_addr[ADDR_W-1 -: BLK_W]),
        .stat      (stat),
        .prot      (prot),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );

    assign rd_src    = st_q.mode;
    assign arr_we    = st_q.we;
    assign arr_erase = st_q.er;
    assign arr_addr  = st_q.addr;
    assign arr_wdata = st_q.data;
endmodule

// File: rtl/fci_sva.sv
module fci_sva #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [7:0]        stat,
    input logic              arr_we,
    input logic              arr_erase
);
    a_r1_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stat == 8'h80);

    a_r12_susp_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[6] || stat[2]) |-> stat[7]);

    a_r12_one_suspend_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat[6] && stat[2]));

    a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);

    a_r5_erase_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |=> !arr_erase);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && arr_erase));

    a_r4_strobe_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || arr_erase) |-> $past(stat[7]) == 1'b0);

    a_r14_prot_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[1]) |-> $past(wr_en && wr_data[7:0] == 8'h50));

    a_r14_seq_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[4]) |-> $past(wr_en && wr_data[7:0] == 8'h50));

    a_r14_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] == 1'b0);
endmodule

bind flash_cmd_ctrl fci_sva #(.DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .stat      (stat),
    .arr_we    (arr_we),
    .arr_erase (arr_erase)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int BW = 3;
    localparam int NP = 12;
    localparam int NE = 40;
    localparam int NB = 8;
    localparam logic [15:0] MFR = 16'h00A5;
    localparam logic [15:0] DEV = 16'h5A3C;
    localparam logic [15:0] CFG = 16'hBE4F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [1:0] rd_src;
    logic [7:0] stat;
    logic pp_ok = 1'b1;
    logic [DW-1:0] arr_rdata;
    logic arr_blank = 1'b1;
    logic arr_we, arr_erase;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .BLK_W(BW),
        .PROG_CYCLES(NP), .ERASE_CYCLES(NE), .BLANK_CYCLES(NB),
        .MFR_CODE(MFR), .DEV_CODE(DEV), .CFG_WORD(CFG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_src(rd_src), .stat(stat), .pp_ok(pp_ok),
        .arr_rdata(arr_rdata), .arr_blank(arr_blank), .arr_we(arr_we), .arr_erase(arr_erase),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // array stub
    logic [DW-1:0] mem [0:(1<<AW)-1];
    initial for (int i = 0; i < (1 << AW); i++) mem[i] = '1;
    assign arr_rdata = mem[rd_addr];
    always @(posedge clk) begin
        if (arr_we) mem[arr_addr] <= arr_wdata;
        if (arr_erase)
            for (int i = 0; i < (1 << (AW - BW)); i++)
                mem[{arr_addr[AW-1 -: BW], (AW-BW)'(i)}] <= '1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle 1 prog-setup 2 erase-setup 3 blank-setup 4 prot-setup 5 busy
    int m_ph, m_op, m_sus, m_mode, m_left;
    bit m_e5, m_e4, m_e3, m_e1, m_we, m_er;
    bit [AW-1:0] m_ad;
    bit [DW-1:0] m_dt;
    bit m_prot [0:(1<<BW)-1];

    function automatic logic [7:0] m_stat();
        return {m_ph != 5, m_sus == 2, m_e5, m_e4, m_e3, m_sus == 1, m_e1, 1'b0};
    endfunction

    function automatic logic [DW-1:0] m_read();
        if (m_mode == 1) return DW'(m_stat());
        if (m_mode == 2) begin
            case (rd_addr[1:0])
                2'd0: return MFR;
                2'd1: return DEV;
                2'd2: return DW'(m_prot[rd_addr >> (AW - BW)]);
                default: return CFG;
            endcase
        end
        return mem[rd_addr];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_op = 0; m_sus = 0; m_mode = 0; m_left = 0;
            {m_e5, m_e4, m_e3, m_e1, m_we, m_er} = '0;
            m_ad = '0; m_dt = '0;
            for (int i = 0; i < (1 << BW); i++) m_prot[i] = 1'b1;
        end else begin
            automatic int c = wr_data[7:0];
            automatic int b = wr_addr >> (AW - BW);
            m_we = 0; m_er = 0;
            if (m_ph == 5) begin
                if (m_left == 1) begin
                    m_ph = 0;
                    if (m_op == 0) m_we = 1;
                    else if (m_op == 1) m_er = 1;
                    else if (!arr_blank) m_e5 = 1;
                end else begin
                    m_left--;
                    if (wr_en && c == 'h70) m_mode = 1;
                    if (wr_en && c == 'hB0 && m_op != 2) begin
                        m_left++;
                        m_ph = 0; m_sus = m_op + 1; m_mode = 1;
                    end
                end
            end else if (wr_en) begin
                if (m_ph == 0) begin
                    if (c == 'hFF) m_mode = 0;
                    else if (c == 'h70) m_mode = 1;
                    else if (c == 'h90) m_mode = 2;
                    else if (c == 'h50) {m_e5, m_e4, m_e3, m_e1} = '0;
                    else if (c == 'h60) m_ph = 4;
                    else if (m_sus == 0 && (c == 'h40 || c == 'h10)) begin m_ph = 1; m_mode = 1; end
                    else if (m_sus == 0 && c == 'h20) begin m_ph = 2; m_mode = 1; end
                    else if (m_sus == 0 && c == 'hBC) begin m_ph = 3; m_mode = 1; end
                    else if (m_sus != 0 && c == 'hD0) begin m_ph = 5; m_sus = 0; m_mode = 1; end
                end else if (m_ph == 4) begin
                    m_ph = 0;
                    if (c == 'h01) m_prot[b] = 1;
                    else if (c == 'hD0) m_prot[b] = 0;
                    else begin m_e5 = 1; m_e4 = 1; end
                end else begin
                    automatic int kind = m_ph;
                    m_ph = 0;
                    if ((kind == 2 && c != 'hD0) || (kind == 3 && c != 'hCB)) begin m_e5 = 1; m_e4 = 1; end
                    else if (!pp_ok) m_e3 = 1;
                    else if (kind != 3 && m_prot[b]) m_e1 = 1;
                    else begin
                        m_ph = 5; m_op = kind - 1; m_ad = wr_addr;
                        if (kind == 1) m_dt = wr_data;
                        m_left = (kind == 1) ? NP : (kind == 2) ? NE : NB;
                    end
                end
            end
        end
    end

    // every-cycle comparison
    always @(negedge clk) if (rst_n) begin
        chk("R14 status", stat, m_stat());
        chk("R10 read source", rd_src, m_mode);
        chk("R2 read data", rd_data, m_read());
        chk("R4 program strobe", arr_we, m_we);
        chk("R5 erase strobe", arr_erase, m_er);
        if (arr_we || arr_erase) chk("R4 strobe address", arr_addr, m_ad);
        if (arr_we) chk("R4 strobe data", arr_wdata, m_dt);
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] code, input logic [DW-1:0] full = 0,
                      input bit use_full = 0);
        wr_en = 1'b1; wr_addr = a;
        wr_data = use_full ? full : DW'(code);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 reset status", stat, 8'h80);
        chk("R1 reset source", rd_src, 2'd0);
        wr(0, 8'h90);
        for (int k = 0; k < 8; k++) begin
            rd_addr = AW'((k << (AW - BW)) | 2); #1;
            chk("R1 protected at reset", rd_data, 16'h0001);
        end
        // R2 identification words
        rd_addr = 12'h000; #1; chk("R2 maker code", rd_data, MFR);
        rd_addr = 12'h001; #1; chk("R2 device code", rd_data, DEV);
        rd_addr = 12'h003; #1; chk("R2 config word", rd_data, CFG);
        wr(0, 8'h70);
        chk("R2 status source", rd_src, 2'd1);
        chk("R2 status read", rd_data, 16'h0080);
        // R7 program to protected block 0, R10 source switch
        wr(0, 8'hFF);
        wr(12'h010, 8'h40);
        chk("R10 status after setup", rd_src, 2'd1);
        wr(12'h010, 0, 16'h1111, 1);
        chk("R7 protect error", stat, 8'h82);
        // R14 clear
        wr(0, 8'h50);
        chk("R14 cleared", stat, 8'h80);
        // R3 unprotect block 1, bad second code
        wr(12'h200, 8'h60); wr(12'h200, 8'hD0);
        wr(12'h200, 8'h90); rd_addr = 12'h202; #1;
        chk("R3 unprotect", rd_data, 16'h0000);
        wr(12'h400, 8'h60); wr(12'h400, 8'h77);
        chk("R3 bad protect code", stat, 8'hB0);
        rd_addr = 12'h402; #1;
        chk("R3 no change on bad code", rd_data, 16'h0001);
        wr(0, 8'h50);
        // R4 program timing
        wr(12'h234, 8'h10);
        wr(12'h234, 0, 16'hC3A5, 1);
        idle(NP - 1);
        chk("R4 busy for full count", stat[7], 1'b0);
        idle(1);
        chk("R4 ready after count", stat[7], 1'b1);
        chk("R4 strobe", arr_we, 1'b1);
        idle(1);
        wr(0, 8'hFF); rd_addr = 12'h234; #1;
        chk("R4 array written", rd_data, 16'hC3A5);
        // R5 erase
        wr(12'h200, 8'h20); wr(12'h200, 8'hD0);
        idle(NE - 1);
        chk("R5 busy for full count", stat[7], 1'b0);
        idle(2);
        wr(0, 8'hFF); rd_addr = 12'h234; #1;
        chk("R5 block erased", rd_data, 16'hFFFF);
        // R8 bad confirm
        wr(12'h200, 8'h20); wr(12'h200, 8'h33);
        chk("R8 sequence error", stat, 8'hB0);
        wr(12'h200, 8'hBC); wr(12'h200, 8'hD0);
        chk("R8 blank bad confirm", stat, 8'hB0);
        wr(0, 8'h50);
        // R6 blank check
        arr_blank = 1'b0;
        wr(12'h200, 8'hBC); wr(12'h200, 8'hCB);
        wr(12'h200, 8'hB0);
        chk("R12 blank check not suspended", stat, 8'h00);
        idle(NB - 1);
        chk("R6 blank fail flag", stat, 8'hA0);
        wr(0, 8'h50);
        arr_blank = 1'b1;
        wr(12'h200, 8'hBC); wr(12'h200, 8'hCB); idle(NB);
        chk("R6 blank pass", stat, 8'h80);
        // R9 voltage, checked before protect
        pp_ok = 1'b0;
        wr(12'h010, 8'h40); wr(12'h010, 0, 16'h2222, 1);
        chk("R9 voltage error first", stat, 8'h88);
        pp_ok = 1'b1;
        // R11 busy ignores, R14 sticky across busy clear
        wr(12'h300, 8'h40); wr(12'h300, 0, 16'h5A5A, 1);
        wr(0, 8'hFF);
        chk("R11 read mode ignored", rd_src, 2'd1);
        wr(0, 8'h50);
        chk("R11 clear ignored when busy", stat[3], 1'b1);
        wr(12'h400, 8'h60); wr(12'h400, 8'hD0);
        idle(NP);
        wr(0, 8'h90); rd_addr = 12'h402; #1;
        chk("R11 protect ignored when busy", rd_data, 16'h0001);
        wr(0, 8'h50);
        // R12 program suspend/resume
        wr(12'h210, 8'h40); wr(12'h210, 0, 16'h0F0F, 1);
        idle(3);
        wr(0, 8'hB0);
        chk("R12 program suspended", stat, 8'h84);
        wr(0, 8'hFF); rd_addr = 12'h300; #1;
        chk("R13 array read in suspend", rd_data, 16'h5A5A);
        wr(0, 8'hD0);
        idle(NP - 4);
        chk("R12 remaining busy", stat[7], 1'b0);
        idle(1);
        chk("R12 resumed completion", arr_we, 1'b1);
        // R13 erase suspend with protect and ignored setup
        wr(12'h200, 8'h20); wr(12'h200, 8'hD0);
        idle(2);
        wr(0, 8'hB0);
        chk("R12 erase suspended", stat, 8'hC0);
        wr(12'h200, 8'h60); wr(12'h200, 8'h01);
        wr(0, 8'h90); rd_addr = 12'h202; #1;
        chk("R13 protect in suspend", rd_data, 16'h0001);
        wr(12'h600, 8'h40);
        chk("R13 setup ignored in suspend", stat, 8'hC0);
        wr(0, 8'hD0);
        chk("R12 erase resumed", stat, 8'h00);
        idle(NE);
        chk("R14 final status", stat, 8'h80);
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule